// File: doc/BRIEF.md
# Serial-Bus Audio Control Receiver

This block is a write-only target on a two-wire serial control bus (I2C) for a stereo audio processor. It receives SCL and SDA that have already been synchronised to the system clock. It detects start and stop conditions and shifts in bytes MSB first. It compares the first byte with a fixed device address and acknowledges by driving an open-drain pull-down enable during the ninth clock.

No pointer register is used. Each data byte after the address carries a leading prefix, and that prefix routes the byte to one setting. The settings are master volume, four speaker attenuators with mute, the input selector with gain and loudness, bass and treble. Any number of data bytes may follow one address. Each setting leaves the block as a decoded step code.

Top module: `aud_ctrl_i2c`

## Requirements
- R1: A transfer opens only on a start (SDA falling while SCL is high). After a stop (SDA rising while SCL is high), bytes clocked without a new start are not acknowledged and change no setting.
- R2: The address byte 8'h88 (bit 0 = 0, write) is acknowledged. `sda_pd_o` is high across the whole ninth SCL high period and is released after the ninth SCL falling edge.
- R3: Any other address byte, including 8'h89 (read), is not acknowledged. All following bytes are ignored until the next start or stop.
- R4: After a matching address, every data byte is acknowledged, whatever its value and however many bytes follow.
- R5: A byte 2'b00,B[2:0],A[2:0] sets `vol_att_o` = 8*B + A, in 1.25 dB attenuation steps.
- R6: A byte with bit 7 = 1 sets one speaker. Bits [6:5] select the speaker: 00 left-front (slot 0), 01 right-front (slot 1), 10 left-rear (slot 2), 11 right-rear (slot 3). Slot k of `spk_att_o` is bits [5k+4:5k] and takes bits [4:0] of the byte (8*B + A, in 1.25 dB steps). `spk_mute_o[k]` is set when bits [4:0] = 5'b11111 and is cleared otherwise.
- R7: A byte 3'b010,G[1:0],L,S[1:0] sets `in_sel_o` = S, `loud_on_o` = !L and `in_gain_o` = 3 - G, in 3.75 dB boost steps. When S = 2'b11, the byte is acknowledged and the selector, gain and loudness all keep their values.
- R8: A byte 4'b0110,C or 4'b0111,C sets bass or treble respectively. The value is a signed count of 2 dB steps: C[2:0] - 7 when C[3] = 0, and 7 - C[2:0] when C[3] = 1.
- R9: A setting changes only as the result of a data byte, and the new value is visible during the ninth SCL high period of that byte.
- R10: A repeated start (a start with no stop before it) returns the block to address matching.
- R11: After reset, the settings are: `vol_att_o` = 63; every speaker muted with attenuation 31; input 0; gain code 0; loudness off; bass and treble 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data (the wired line) |
| sda_pd_o | output | 1 | Pull-down enable for SDA (acknowledge) |
| vol_att_o | output | 6 | Volume attenuation, 1.25 dB steps |
| spk_att_o | output | 20 | Four 5-bit speaker attenuations, LF/RF/LR/RR from bit 0 up |
| spk_mute_o | output | 4 | Speaker mute flags, same slot order |
| in_sel_o | output | 2 | Selected stereo input 0..2 |
| in_gain_o | output | 2 | Input boost, 3.75 dB steps |
| loud_on_o | output | 1 | Loudness enabled |
| bass_o | output | 4 | Signed bass, 2 dB steps |
| treble_o | output | 4 | Signed treble, 2 dB steps |

## Verification
Both the acknowledge drive and the write of a data byte into its setting are triggered by the same eighth SCL falling edge, so both must be visible together in the ninth clock. The bench plays bus master and streams all 256 byte values in one burst. During each ninth SCL high it samples the line for the acknowledge and also compares every setting with an arithmetic model in decibels. A late write or an early or dropped acknowledge then shows up at that byte.

// File: rtl/aud_ctrl_pkg.sv
package aud_ctrl_pkg;
  localparam int NUM_SPK   = 4;
  localparam int SPK_W     = 5;
  localparam int VOL_W     = 6;
  localparam int TONE_W    = 4;
  localparam int BYTE_W    = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {RX_IDLE, RX_ADDR, RX_DATA, RX_SKIP} rx_state_e;

  // signed 2 dB step count from the sign-magnitude-like tone code
  function automatic logic signed [TONE_W-1:0] tone_decode(input logic [3:0] c);
    logic signed [4:0] m;
    m = {2'b00, c[2:0]};
    return c[3] ? TONE_W'(5'sd7 - m) : TONE_W'(m - 5'sd7);
  endfunction
endpackage

// File: rtl/aud_i2c_cond.sv
module aud_i2c_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/aud_i2c_rx.sv
module aud_i2c_rx
  import aud_ctrl_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_ADDR = 8'h88
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  output logic              sda_pd_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output rx_state_e         state_o
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);
  localparam logic [BYTE_W-1:0]    WR_ADDR  = {DEV_ADDR[BYTE_W-1:1], 1'b0};

  rx_state_e              state_q;
  logic [BIT_CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]      sh_q;
  logic                   ack_ph_q, pd_q, wr_q;
  logic                   live;

  assign live = (state_q == RX_ADDR) || (state_q == RX_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      ack_ph_q <= 1'b0;
      pd_q     <= 1'b0;
      wr_q     <= 1'b0;
    end else if (start_i) begin
      state_q  <= RX_ADDR;
      cnt_q    <= '0;
      ack_ph_q <= 1'b0;
      pd_q     <= 1'b0;
      wr_q     <= 1'b0;
    end else if (stop_i) begin
      state_q  <= RX_IDLE;
      cnt_q    <= '0;
      ack_ph_q <= 1'b0;
      pd_q     <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (live) begin
        if (scl_rise_i && cnt_q != LAST_BIT) begin
          sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
          cnt_q <= cnt_q + 1'b1;
        end
        if (scl_fall_i && cnt_q == LAST_BIT) begin
          if (!ack_ph_q) begin
            // eighth falling edge: open the acknowledge slot
            ack_ph_q <= 1'b1;
            if (state_q == RX_DATA) begin
              pd_q <= 1'b1;
              wr_q <= 1'b1;
            end else if (sh_q == WR_ADDR) begin
              pd_q <= 1'b1;
            end else begin
              state_q <= RX_SKIP;
            end
          end else begin
            ack_ph_q <= 1'b0;
            pd_q     <= 1'b0;
            cnt_q    <= '0;
            if (state_q == RX_ADDR) state_q <= RX_DATA;
          end
        end
      end
    end
  end

  assign sda_pd_o  = pd_q;
  assign wr_stb_o  = wr_q;
  assign wr_data_o = sh_q;
  assign state_o   = state_q;
endmodule

// File: rtl/aud_reg_bank.sv
module aud_reg_bank
  import aud_ctrl_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_stb_i,
  input  logic [BYTE_W-1:0]         wr_data_i,
  output logic [VOL_W-1:0]          vol_att_o,
  output logic [NUM_SPK*SPK_W-1:0]  spk_att_o,
  output logic [NUM_SPK-1:0]        spk_mute_o,
  output logic [1:0]                in_sel_o,
  output logic [1:0]                in_gain_o,
  output logic                      loud_on_o,
  output logic signed [TONE_W-1:0]  bass_o,
  output logic signed [TONE_W-1:0]  treble_o
);
  localparam logic [SPK_W-1:0] SPK_MUTE_CODE = '1;

  logic wr_vol, wr_sw, wr_tone;
  assign wr_vol  = wr_stb_i && wr_data_i[7:6] == 2'b00;
  assign wr_sw   = wr_stb_i && wr_data_i[7:5] == 3'b010 && wr_data_i[1:0] != 2'b11;
  assign wr_tone = wr_stb_i && wr_data_i[7:5] == 3'b011;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_att_o <= '1;
      in_sel_o  <= '0;
      in_gain_o <= '0;
      loud_on_o <= 1'b0;
      bass_o    <= '0;
      treble_o  <= '0;
    end else begin
      if (wr_vol) vol_att_o <= wr_data_i[VOL_W-1:0];
      if (wr_sw) begin
        in_sel_o  <= wr_data_i[1:0];
        loud_on_o <= ~wr_data_i[2];
        in_gain_o <= 2'd3 - wr_data_i[4:3];
      end
      if (wr_tone) begin
        if (wr_data_i[4]) treble_o <= tone_decode(wr_data_i[3:0]);
        else              bass_o   <= tone_decode(wr_data_i[3:0]);
      end
    end
  end

  for (genvar k = 0; k < NUM_SPK; k++) begin : g_spk
    logic wr_k;
    assign wr_k = wr_stb_i && wr_data_i[7] && wr_data_i[6:5] == 2'(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        spk_att_o[k*SPK_W +: SPK_W] <= SPK_MUTE_CODE;
        spk_mute_o[k]               <= 1'b1;
      end else if (wr_k) begin
        spk_att_o[k*SPK_W +: SPK_W] <= wr_data_i[SPK_W-1:0];
        spk_mute_o[k]               <= wr_data_i[SPK_W-1:0] == SPK_MUTE_CODE;
      end
    end
  end
endmodule

// File: rtl/aud_ctrl_i2c.sv
module aud_ctrl_i2c
  import aud_ctrl_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'h88
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_pd_o,
  output logic [5:0]               vol_att_o,
  output logic [19:0]              spk_att_o,
  output logic [3:0]               spk_mute_o,
  output logic [1:0]               in_sel_o,
  output logic [1:0]               in_gain_o,
  output logic                     loud_on_o,
  output logic signed [3:0]        bass_o,
  output logic signed [3:0]        treble_o
);
  logic        start_w, stop_w, rise_w, fall_w, wr_stb_w;
  logic [7:0]  wr_data_w;
  rx_state_e   rx_state_w;

  aud_i2c_cond u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .start_o(start_w), .stop_o(stop_w), .scl_rise_o(rise_w), .scl_fall_o(fall_w)
  );

  aud_i2c_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk_i, .rst_ni,
    .start_i(start_w), .stop_i(stop_w), .scl_rise_i(rise_w), .scl_fall_i(fall_w),
    .sda_i, .sda_pd_o, .wr_stb_o(wr_stb_w), .wr_data_o(wr_data_w), .state_o(rx_state_w)
  );

  aud_reg_bank u_bank (
    .clk_i, .rst_ni, .wr_stb_i(wr_stb_w), .wr_data_i(wr_data_w),
    .vol_att_o, .spk_att_o, .spk_mute_o, .in_sel_o, .in_gain_o, .loud_on_o,
    .bass_o, .treble_o
  );
endmodule

// File: rtl/aud_ctrl_chk.sv
module aud_ctrl_chk
  import aud_ctrl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_pd_o,
  input logic              start_w,
  input logic              stop_w,
  input logic              wr_stb_w,
  input rx_state_e         rx_state_w,
  input logic [5:0]        vol_att_o,
  input logic [19:0]       spk_att_o,
  input logic [3:0]        spk_mute_o,
  input logic [1:0]        in_sel_o,
  input logic signed [3:0] bass_o,
  input logic signed [3:0] treble_o
);
  AST_PD_STABLE_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && !$past(start_w) && !$past(stop_w)) |-> $stable(sda_pd_o)); // R2

  AST_WRITE_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_w |-> (sda_pd_o && !scl_i)); // R9

  AST_NO_ACK_UNADDRESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_state_w == RX_SKIP || rx_state_w == RX_IDLE) |-> !sda_pd_o); // R3

  AST_VOL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_w |=> $stable(vol_att_o)); // R9

  AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_sel_o != 2'b11); // R7

  AST_TONE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bass_o != -4'sd8 && treble_o != -4'sd8); // R8

  for (genvar k = 0; k < 4; k++) begin : g_mute
    AST_MUTE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spk_mute_o[k] |-> spk_att_o[k*5 +: 5] == 5'h1f); // R6
  end
endmodule

bind aud_ctrl_i2c aud_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_pd_o(sda_pd_o),
  .start_w(start_w), .stop_w(stop_w), .wr_stb_w(wr_stb_w), .rx_state_w(rx_state_w),
  .vol_att_o(vol_att_o), .spk_att_o(spk_att_o), .spk_mute_o(spk_mute_o),
  .in_sel_o(in_sel_o), .bass_o(bass_o), .treble_o(treble_o)
);

// File: tb/aud_ctrl_i2c_tb.sv
`timescale 1ns/1ps
module aud_ctrl_i2c_tb_top;
  localparam int Q = 6;

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda_m = 1;
  logic sda_pd;
  logic [5:0] vol_att;
  logic [19:0] spk_att;
  logic [3:0] spk_mute;
  logic [1:0] in_sel, in_gain;
  logic loud_on;
  logic signed [3:0] bass, treble;
  wire sda_line = sda_m & ~sda_pd;

  always #2 clk = ~clk;

  aud_ctrl_i2c dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pd_o(sda_pd),
    .vol_att_o(vol_att), .spk_att_o(spk_att), .spk_mute_o(spk_mute),
    .in_sel_o(in_sel), .in_gain_o(in_gain), .loud_on_o(loud_on),
    .bass_o(bass), .treble_o(treble)
  );

  int checks = 0, errors = 0;
  // model, in centi-dB / dB
  int m_vol, m_spk[4], m_sel, m_gain, m_bass, m_treb;
  bit m_mute[4], m_loud;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic model_reset();
    m_vol = 7875; m_sel = 0; m_gain = 0; m_loud = 0; m_bass = 0; m_treb = 0;
    for (int k = 0; k < 4; k++) begin m_spk[k] = 3875; m_mute[k] = 1; end
  endtask

  task automatic model_write(input logic [7:0] d);
    int t;
    if (d[7:6] == 2'b00) m_vol = 1000 * int'(d[5:3]) + 125 * int'(d[2:0]);
    else if (d[7]) begin
      m_spk[d[6:5]]  = 1000 * int'(d[4:3]) + 125 * int'(d[2:0]);
      m_mute[d[6:5]] = (d[4:0] == 5'b11111);
    end else if (d[7:5] == 3'b010) begin
      if (d[1:0] != 2'b11) begin
        m_sel = int'(d[1:0]); m_loud = !d[2]; m_gain = 1125 - 375 * int'(d[4:3]);
      end
    end else begin
      t = d[3] ? 2 * (7 - int'(d[2:0])) : -14 + 2 * int'(d[2:0]);
      if (d[4]) m_treb = t; else m_bass = t;
    end
  endtask

  task automatic check_regs(input string tag);
    chk(int'(vol_att) * 125 == m_vol, {"R5 volume ", tag}, int'(vol_att) * 125, m_vol);
    for (int k = 0; k < 4; k++) begin
      chk(int'(spk_att[k*5 +: 5]) * 125 == m_spk[k], {"R6 speaker att ", tag},
          int'(spk_att[k*5 +: 5]) * 125, m_spk[k]);
      chk(spk_mute[k] == m_mute[k], {"R6 speaker mute ", tag}, int'(spk_mute[k]), int'(m_mute[k]));
    end
    chk(int'(in_sel) == m_sel, {"R7 input select ", tag}, int'(in_sel), m_sel);
    chk(int'(in_gain) * 375 == m_gain, {"R7 gain ", tag}, int'(in_gain) * 375, m_gain);
    chk(loud_on == m_loud, {"R7 loudness ", tag}, int'(loud_on), int'(m_loud));
    chk(int'(bass) * 2 == m_bass, {"R8 bass ", tag}, int'(bass) * 2, m_bass);
    chk(int'(treble) * 2 == m_treb, {"R8 treble ", tag}, int'(treble) * 2, m_treb);
  endtask

  task automatic bus_start();
    sda_m = 1; wq(Q); scl = 1; wq(Q); sda_m = 0; wq(Q); scl = 0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(Q); scl = 1; wq(Q); sda_m = 1; wq(Q);
  endtask

  // sends a byte; returns ack seen and checks settings mid ninth clock (R9)
  task automatic send_byte(input logic [7:0] d, input bit regs_chk, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = d[i]; wq(Q); scl = 1; wq(2 * Q); scl = 0; wq(Q);
    end
    sda_m = 1; wq(Q); scl = 1; wq(Q);
    ack = !sda_line;
    if (regs_chk) check_regs("at ninth clock R9");
    wq(Q); scl = 0; wq(Q);
  endtask

  bit ack;

  initial begin
    model_reset();
    wq(5); rst_n = 1; wq(3);
    check_regs("after reset R11");
    chk(sda_pd == 0, "R11 no pull-down at reset", int'(sda_pd), 0);

    // R3 wrong address, then a data byte must be ignored
    bus_start();
    send_byte(8'h90, 0, ack); chk(!ack, "R3 wrong address acked", int'(ack), 0);
    send_byte(8'h00, 0, ack); chk(!ack, "R3 byte after wrong address acked", int'(ack), 0);
    check_regs("after wrong address R3");
    bus_stop();
    // R3 read bit
    bus_start();
    send_byte(8'h89, 0, ack); chk(!ack, "R3 read address acked", int'(ack), 0);
    bus_stop();

    // R1 byte clocked after stop without a start
    scl = 0; wq(Q);
    send_byte(8'h00, 0, ack); chk(!ack, "R1 byte without start acked", int'(ack), 0);
    check_regs("after byte without start R1");
    bus_stop();

    // R4 burst of every byte value behind one address
    bus_start();
    send_byte(8'h88, 0, ack); chk(ack, "R2 address ack", int'(ack), 1);
    chk(sda_pd == 0, "R2 release after address ack", int'(sda_pd), 0);
    for (int v = 0; v < 256; v++) begin
      model_write(8'(v));
      send_byte(8'(v), 1, ack);
      chk(ack, "R4 data byte ack", int'(ack), 1);
      chk(sda_pd == 0, "R2 release after data ack", int'(sda_pd), 0);
    end
    bus_stop();
    check_regs("after burst R4");

    // R7 illegal selector after a legal one
    bus_start();
    send_byte(8'h88, 0, ack);
    model_write(8'h49); send_byte(8'h49, 1, ack);
    send_byte(8'h43, 1, ack); chk(ack, "R7 illegal selector acked", int'(ack), 1);
    bus_stop();

    // R10 repeated start into a wrong address, data ignored
    bus_start();
    send_byte(8'h88, 0, ack);
    model_write(8'h05); send_byte(8'h05, 1, ack);
    bus_start();
    send_byte(8'h90, 0, ack); chk(!ack, "R10 wrong address after repeated start", int'(ack), 0);
    send_byte(8'h00, 0, ack); chk(!ack, "R10 data ignored after repeated start", int'(ack), 0);
    chk(int'(vol_att) == 5, "R10 volume kept", int'(vol_att), 5);
    bus_start();
    send_byte(8'h88, 0, ack); chk(ack, "R10 matching address after repeated start", int'(ack), 1);
    model_write(8'hA4); send_byte(8'hA4, 1, ack);
    bus_stop();
    check_regs("end R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule